// File: doc/BRIEF.md
# Suspendable Burst Access Controller

This block runs synchronous burst reads and writes into a small pseudo-static memory array. A start address is captured when the chip is selected and the address strobe is sampled low. The level of the write strobe on that capture edge picks the direction. After a fixed initial latency, an internal address counter steps once per clock, wrapping inside the aligned block of the configured burst length.

During a burst, the host can pause the transfer by holding a strobe high:
- In a read burst, holding the output-enable strobe high pauses it. The counter holds and the data bus is released. When the strobe drops, the element that was cut off is presented again.
- In a write burst with the level-controlled write mode selected, holding the write strobe high pauses it. Incoming data is then dropped. Writing resumes at the address that was skipped.

A pause request on the first beat of a burst is refused. Deselecting the chip ends the burst immediately.

Top module: `burstSuspendCtl`

## Requirements
- R1: With `ceN` low and `advN` sampled low on a clock edge while idle, `addr` is captured as the start address. `weN` low on that edge starts a write burst; `weN` high starts a read burst.
- R2: The first read beat is presented (`dOutEn`=1, `waitN`=1) exactly LATENCY edges after the capture edge. Before that, `dOutEn` and `waitN` stay 0 whatever `oeN` does.
- R3: Each consumed beat advances the address by one. With BURST_LEN of 4, 8 or 16, only the low log2(BURST_LEN) address bits count, so the address wraps inside its aligned block. BURST_LEN=0 means a linear count over the whole array.
- R4: In a read burst, `oeN` sampled high on any beat edge but the first pauses the burst. From the next cycle, `dOutEn`=0 and `waitN`=0, and the address holds.
- R5: The edge that samples `oeN` low ends a read pause without advancing. The cycle after it presents the same address that was showing when the pause was taken.
- R6: A pause request sampled on the first beat edge of a read or write burst is ignored. That beat completes and the address advances.
- R7: In a write burst, every beat edge that is not paused stores `dIn` at the current address and advances.
- R8: With `wrLevelMode`=1, `weN` sampled high on a write beat edge other than the first pauses the burst: `dIn` is discarded, the address holds, and `waitN`=0 in the next cycle. The edge that samples `weN` low writes `dIn` to the held address.
- R9: With `wrLevelMode`=0, `weN` high during a write burst does not pause it. `waitN` stays 1 and every beat edge writes.
- R10: `ceN` sampled high ends any burst: `dOutEn`=0 and `waitN`=0 from the next cycle. `advN` low during an active burst is ignored.
- R11: While `rstN` is low, the controller is idle with `dOutEn`=0 and `waitN`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip select, active low |
| advN | input | 1 | Start-address strobe, active low |
| addr | input | ADDR_W | Start address |
| oeN | input | 1 | Output enable, active low; high pauses a read burst |
| weN | input | 1 | Write strobe, active low; picks direction at start, high pauses a level-mode write |
| wrLevelMode | input | 1 | 1 = write bursts may be paused by `weN`, 0 = they may not |
| dIn | input | DATA_W | Write data from the bus |
| dOut | output | DATA_W | Read data to the bus (zero when not driven) |
| dOutEn | output | 1 | Bus drive enable for `dOut` |
| waitN | output | 1 | 1 when the current beat is valid, 0 during latency, pauses and idle |

## Verification
The embedded assertions watch, on every cycle, the relations that one edge implies for the next:
- deselection clears the bus drive and ready;
- a first beat is always followed by ready;
- a read pause request releases the bus on the following cycle;
- edge-mode writes never drop ready;
- a burst load never coincides with a write strobe.

Some properties span a whole burst or depend on stored data, and only the bench scenarios can show them. These are the doubled element across a read pause, skipped and resumed write addresses, wrap inside the aligned block, and the exact latency count. The bench shows them by reading memory contents back and comparing the sequence of presented beats.

// File: rtl/bscPkg.sv
package bscPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_DATA = 2'd2
  } bscState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture start address
    logic advance;  // step the burst counter
    logic write;    // store input data at the current address
  } bscStrobe_t;

endpackage

// File: rtl/bscControl.sv
module bscControl
  import bscPkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       advN,
  input  logic       oeN,
  input  logic       weN,
  input  logic       wrLevelMode,
  output bscStrobe_t strb,
  output logic       dOutEn,
  output logic       waitN
);

  localparam int LAT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  bscState_e  state;
  logic [LAT_W-1:0] latCnt;
  logic isWrite;
  logic firstBeat;
  logic paused;

  logic inData;
  logic suspReq;
  logic takePause;

  assign inData    = (state == ST_DATA);
  assign suspReq   = isWrite ? (weN && wrLevelMode) : oeN;
  // A pause request on the first beat is refused
  assign takePause = inData && suspReq && !firstBeat;

  always_comb begin
    strb.load    = (state == ST_IDLE) && !ceN && !advN;
    strb.write   = inData && !ceN && isWrite && !takePause;
    // A read resume spends one cycle re-presenting the held element
    strb.advance = inData && !ceN && !takePause && (isWrite || !paused);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      latCnt    <= '0;
      isWrite   <= 1'b0;
      firstBeat <= 1'b0;
      paused    <= 1'b0;
    end else if (ceN) begin
      state     <= ST_IDLE;
      firstBeat <= 1'b0;
      paused    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!advN) begin
            state   <= ST_LAT;
            latCnt  <= LAT_W'(LATENCY - 1);
            isWrite <= !weN;
          end
        end
        ST_LAT: begin
          if (latCnt == '0) begin
            state     <= ST_DATA;
            firstBeat <= 1'b1;
            paused    <= 1'b0;
          end else begin
            latCnt <= latCnt - 1'b1;
          end
        end
        ST_DATA: begin
          paused <= takePause;
          if (!takePause) firstBeat <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dOutEn = inData && !isWrite && !paused;
  assign waitN  = inData && !paused;

  AST_CE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> (!dOutEn && !waitN)); // R10

  AST_FIRST_BEAT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (inData && firstBeat && !ceN) |=> waitN); // R6

  AST_READ_SUSPEND: assert property (@(posedge clk) disable iff (!rstN)
    (inData && !isWrite && !firstBeat && oeN && !ceN) |=> (!dOutEn && !waitN)); // R4

  AST_EDGE_MODE_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (inData && isWrite && !wrLevelMode && !ceN) |=> waitN); // R9

endmodule

// File: rtl/bscDatapath.sv
module bscDatapath
  import bscPkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bscStrobe_t        strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] nextAddr;

  generate
    if (BURST_LEN == 0) begin : g_linear
      assign nextAddr = curAddr + 1'b1;
    end else begin : g_wrap
      localparam int LB = $clog2(BURST_LEN);
      logic [LB-1:0] lowNext;
      assign lowNext  = curAddr[LB-1:0] + LB'(1);
      assign nextAddr = {curAddr[ADDR_W-1:LB], lowNext};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (strb.load) begin
      curAddr <= addrIn;
    end else if (strb.advance) begin
      curAddr <= nextAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.write) mem[curAddr] <= dIn;
  end

  assign rdData = mem[curAddr];

  AST_LOAD_NOT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !strb.write); // R1

endmodule

// File: rtl/burstSuspendCtl.sv
module burstSuspendCtl
  import bscPkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 8,
  parameter int LATENCY   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              advN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oeN,
  input  logic              weN,
  input  logic              wrLevelMode,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn,
  output logic              waitN
);

  bscStrobe_t        strb;
  logic [DATA_W-1:0] rdData;

  bscControl #(
    .LATENCY (LATENCY)
  ) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .ceN         (ceN),
    .advN        (advN),
    .oeN         (oeN),
    .weN         (weN),
    .wrLevelMode (wrLevelMode),
    .strb        (strb),
    .dOutEn      (dOutEn),
    .waitN       (waitN)
  );

  bscDatapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BURST_LEN (BURST_LEN)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .addrIn (addr),
    .dIn    (dIn),
    .rdData (rdData)
  );

  assign dOut = dOutEn ? rdData : '0;

endmodule

// File: tb/sim_burstSuspendCtl.sv
`timescale 1ns/1ps
module sim_burstSuspendCtl;

  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int BL  = 8;
  localparam int LAT = 3;
  localparam int NA  = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, advN = 1'b1, oeN = 1'b1, weN = 1'b1, wrMode = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic dOutEn, waitN;

  int checks = 0;
  int fails  = 0;
  string curReq = "R11";

  // Behavioural reference model
  int mState = 0, mWr = 0, mLat = 0, mFirst = 0, mPaused = 0, mAddr = 0;
  int mMem [NA];
  bit mValid [NA];
  int gold [NA];
  int gotQ [$];

  always #10 clk = ~clk;  // 50 MHz

  burstSuspendCtl #(.ADDR_W(AW), .DATA_W(DW), .BURST_LEN(BL), .LATENCY(LAT)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .advN(advN), .addr(addr), .oeN(oeN),
    .weN(weN), .wrLevelMode(wrMode), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn),
    .waitN(waitN));

  function automatic int stepA(int a);
    if (BL == 0) return (a + 1) % NA;
    return (a / BL) * BL + ((a % BL) + 1) % BL;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mPaused = 0; mFirst = 0;
    end else begin
      int susp, pause;
      if (dOutEn) gotQ.push_back(int'(dOut));
      susp  = mWr ? int'(weN && wrMode) : int'(oeN);
      pause = (mState == 2 && susp != 0 && mFirst == 0) ? 1 : 0;
      if (ceN) begin
        mState = 0; mPaused = 0; mFirst = 0;
      end else if (mState == 0) begin
        if (!advN) begin
          mAddr = int'(addr); mWr = weN ? 0 : 1; mLat = LAT - 1; mState = 1;
        end
      end else if (mState == 1) begin
        if (mLat == 0) begin
          mState = 2; mFirst = 1; mPaused = 0;
        end else mLat--;
      end else begin
        if (mWr != 0) begin
          if (pause == 0) begin
            mMem[mAddr] = int'(dIn); mValid[mAddr] = 1'b1; mAddr = stepA(mAddr);
          end
        end else if (pause == 0 && mPaused == 0) begin
          mAddr = stepA(mAddr);
        end
        if (pause == 0) mFirst = 0;
        mPaused = pause;
      end
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit expEn, expWait;
      expEn   = (mState == 2 && mWr == 0 && mPaused == 0);
      expWait = (mState == 2 && mPaused == 0);
      check(dOutEn == expEn, curReq, "dOutEn", int'(dOutEn), int'(expEn));
      check(waitN == expWait, curReq, "waitN", int'(waitN), int'(expWait));
      if (expEn && mValid[mAddr])
        check(int'(dOut) == mMem[mAddr], curReq, "dOut", int'(dOut), mMem[mAddr]);
    end
  end

  task automatic edgeIn(input logic ce, input logic adv, input int a,
                        input logic oe, input logic we, input int d);
    @(negedge clk);
    ceN = ce; advN = adv; addr = AW'(a); oeN = oe; weN = we; dIn = DW'(d);
  endtask

  task automatic peek();
    @(posedge clk);
    #5;
  endtask

  task automatic readBurst(input int a, input int n, input string req);
    int p;
    gotQ.delete();
    edgeIn(0, 0, a, 0, 1, 0);
    repeat (LAT) edgeIn(0, 1, 0, 0, 1, 0);
    repeat (n - 1) edgeIn(0, 1, 0, 0, 1, 0);
    edgeIn(1, 1, 0, 1, 1, 0);
    edgeIn(1, 1, 0, 1, 1, 0);
    check(gotQ.size() == n, req, "beat count", gotQ.size(), n);
    p = a;
    for (int i = 0; i < n && i < gotQ.size(); i++) begin
      check(gotQ[i] == gold[p], req, "read-back beat", gotQ[i], gold[p]);
      p = stepA(p);
    end
  endtask

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seqExp [7];
    for (int i = 0; i < NA; i++) mValid[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(dOutEn == 1'b0, "R11", "dOutEn in reset", int'(dOutEn), 0);
    check(waitN == 1'b0, "R11", "waitN in reset", int'(waitN), 0);
    rstN = 1'b1;

    // R7: fill the array with level-mode write bursts, one per aligned block
    curReq = "R7";
    wrMode = 1'b1;
    for (int b = 0; b < NA / BL; b++) begin
      edgeIn(0, 0, b * BL, 1, 0, 0);
      repeat (LAT) edgeIn(0, 1, 0, 1, 0, 0);
      for (int k = 0; k < BL; k++) begin
        gold[b * BL + k] = (16'h1000 + (b * BL + k) * 16'h0101) & 16'hFFFF;
        edgeIn(0, 1, 0, 1, 0, gold[b * BL + k]);
      end
      edgeIn(1, 1, 0, 1, 1, 0);
    end
    readBurst(0, 8, "R7");

    // R2/R4/R5/R6: read from 5 with pause requests in latency, on first beat, mid burst
    curReq = "R2";
    gotQ.delete();
    edgeIn(0, 0, 5, 1, 1, 0);             // E0 capture (R1)
    edgeIn(0, 1, 0, 1, 1, 0);             // E1 latency, oeN high ignored
    edgeIn(0, 1, 0, 1, 1, 0);             // E2
    peek();
    check(dOutEn == 1'b0, "R2", "dOutEn before latency end", int'(dOutEn), 0);
    edgeIn(0, 1, 0, 1, 1, 0);             // E3 enters data
    peek();
    check(dOutEn == 1'b1, "R2", "dOutEn at latency end", int'(dOutEn), 1);
    check(waitN == 1'b1, "R2", "waitN at latency end", int'(waitN), 1);
    curReq = "R6";
    edgeIn(0, 1, 0, 1, 1, 0);             // E4 first beat, pause refused
    curReq = "R4";
    edgeIn(0, 1, 0, 0, 1, 0);             // E5
    edgeIn(0, 1, 0, 1, 1, 0);             // E6 pause
    peek();
    check(dOutEn == 1'b0, "R4", "dOutEn while paused", int'(dOutEn), 0);
    check(waitN == 1'b0, "R4", "waitN while paused", int'(waitN), 0);
    edgeIn(0, 1, 0, 1, 1, 0);             // E7 still paused
    curReq = "R5";
    edgeIn(0, 1, 0, 0, 1, 0);             // E8 resume
    edgeIn(0, 1, 0, 0, 1, 0);             // E9
    edgeIn(0, 1, 0, 0, 1, 0);             // E10
    edgeIn(0, 1, 0, 0, 1, 0);             // E11
    edgeIn(1, 1, 0, 1, 1, 0);             // E12 end
    edgeIn(1, 1, 0, 1, 1, 0);
    seqExp = '{5, 6, 7, 7, 0, 1, 2};
    check(gotQ.size() == 7, "R5", "beats with one repeat", gotQ.size(), 7);
    for (int i = 0; i < 7 && i < gotQ.size(); i++)
      check(gotQ[i] == gold[seqExp[i]], (i == 0) ? "R1" : ((i == 4) ? "R3" : "R5"),
            "read beat order", gotQ[i], gold[seqExp[i]]);

    // R8: level-mode write pause at 16
    curReq = "R8";
    edgeIn(0, 0, 16, 1, 0, 0);
    repeat (LAT) edgeIn(0, 1, 0, 1, 0, 0);
    edgeIn(0, 1, 0, 1, 1, 16'hAA01);      // first beat: pause refused (R6)
    edgeIn(0, 1, 0, 1, 0, 16'hAA02);
    edgeIn(0, 1, 0, 1, 1, 16'hDEAD);      // pause, data dropped
    peek();
    check(waitN == 1'b0, "R8", "waitN in write pause", int'(waitN), 0);
    edgeIn(0, 1, 0, 1, 1, 16'hBEEF);
    edgeIn(0, 1, 0, 1, 0, 16'hAA03);      // resume at held address
    edgeIn(0, 1, 0, 1, 0, 16'hAA04);
    edgeIn(1, 1, 0, 1, 1, 0);
    gold[16] = 16'hAA01; gold[17] = 16'hAA02; gold[18] = 16'hAA03; gold[19] = 16'hAA04;
    readBurst(16, 6, "R8");

    // R9: edge mode, weN high does not pause
    curReq = "R9";
    wrMode = 1'b0;
    edgeIn(0, 0, 32, 1, 0, 0);
    repeat (LAT) edgeIn(0, 1, 0, 1, 0, 0);
    edgeIn(0, 1, 0, 1, 0, 16'hBB01);
    edgeIn(0, 1, 0, 1, 1, 16'hBB02);
    peek();
    check(waitN == 1'b1, "R9", "waitN with weN high in edge mode", int'(waitN), 1);
    edgeIn(0, 1, 0, 1, 1, 16'hBB03);
    edgeIn(0, 1, 0, 1, 0, 16'hBB04);
    edgeIn(1, 1, 0, 1, 1, 0);
    gold[32] = 16'hBB01; gold[33] = 16'hBB02; gold[34] = 16'hBB03; gold[35] = 16'hBB04;
    readBurst(32, 4, "R9");

    // R10: restart strobe mid burst ignored; deselect ends it
    curReq = "R10";
    gotQ.delete();
    edgeIn(0, 0, 40, 0, 1, 0);
    repeat (LAT) edgeIn(0, 1, 0, 0, 1, 0);
    edgeIn(0, 1, 0, 0, 1, 0);
    edgeIn(0, 0, 3, 0, 1, 0);             // advN low mid burst
    edgeIn(0, 1, 0, 0, 1, 0);
    edgeIn(1, 0, 9, 0, 1, 0);             // deselect, advN low does not start
    peek();
    check(dOutEn == 1'b0, "R10", "dOutEn after deselect", int'(dOutEn), 0);
    check(waitN == 1'b0, "R10", "waitN after deselect", int'(waitN), 0);
    check(gotQ.size() == 4, "R10", "beats before deselect", gotQ.size(), 4);
    for (int i = 0; i < 4 && i < gotQ.size(); i++)
      check(gotQ[i] == gold[40 + i], "R10", "beat ignores restart", gotQ[i], gold[40 + i]);
    edgeIn(1, 1, 0, 1, 1, 0);
    repeat (4) edgeIn(1, 1, 0, 1, 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule